// File: doc/BRIEF.md
# Nested Trap Entry and Return Unit

This unit manages trap entry and trap return for a simple in-order core. When the pipeline asks for a trap, the unit saves a full return context on an on-chip stack. That context is the current PC, the next PC and a small processor-state word. The unit then raises the trap level and, in the same cycle, supplies the handler fetch address and the address after it. Each handler slot in the vector table is 32 bytes long, which holds eight 4-byte instructions. The table starts at a programmable base and has a hardware half and a software half.

A trap-return command pops the newest context. In the same cycle the unit drives the saved PC and next PC as the redirect target, together with the saved state word, and the level drops by one. Contexts nest up to a fixed depth. The unit reports a trap that would exceed that depth, and a return made with no context saved, on two error outputs. Neither case changes any state. The trap source can be an instruction exception, an asynchronous error or an unrelated interrupt; the unit treats them all alike through the trap type.

Top module: `trap_nest_unit`

## Requirements
- R1: After reset, trap_level_o is 0, the base register is 0, and trap_taken_o, ret_taken_o, overflow_err_o and illegal_ret_err_o are all low.
- R2: A trap request at a level below 6 is accepted in the same cycle. trap_taken_o is high, redirect_pc_o = base + (trap_type_i << 5) and redirect_npc_o = redirect_pc_o + 4. trap_level_o is one higher after the next clock edge.
- R3: A base write (base_we_i) takes effect after the clock edge, so a trap in the same cycle still uses the old base. The low 14 bits of the base are always read as zero, which aligns the base to the 16 KiB table.
- R4: Trap types 0x000–0x0FF (hardware) select slots in the lower 8 KiB of the table. Types 0x100–0x1FF (software) select slots at offsets 0x2000–0x3FE0.
- R5: An accepted trap saves cur_pc_i, cur_npc_i and cur_pstate_i. An accepted return (ret_taken_o) drives the saved PC on redirect_pc_o, the saved next PC on redirect_npc_o and the saved state on restored_pstate_o in the same cycle. trap_level_o is one lower after the edge.
- R6: A trap request at level 6 raises overflow_err_o in that cycle. It does not push, does not redirect and leaves the level and the saved contexts unchanged.
- R7: A return request at level 0 with no trap request raises illegal_ret_err_o. It does not redirect, and the level stays 0.
- R8: When a trap request and a return request arrive in the same cycle, only the trap is considered. The return has no effect, even when the trap overflows.
- R9: Contexts come back in last-in first-out order across all 6 nesting levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Write strobe for the table base register |
| base_wdata_i | input | 32 | New table base (low 14 bits ignored) |
| trap_req_i | input | 1 | Trap request |
| trap_type_i | input | 9 | Trap type; bit 8 selects the software half |
| ret_req_i | input | 1 | Trap-return command |
| cur_pc_i | input | 32 | PC to save on trap |
| cur_npc_i | input | 32 | Next PC to save on trap |
| cur_pstate_i | input | 8 | Processor-state word to save on trap |
| trap_taken_o | output | 1 | Trap accepted this cycle |
| ret_taken_o | output | 1 | Return accepted this cycle |
| redirect_pc_o | output | 32 | Fetch target (handler or restored PC) |
| redirect_npc_o | output | 32 | Following fetch target |
| restored_pstate_o | output | 8 | Saved state word on return, else 0 |
| trap_level_o | output | 3 | Current trap level |
| overflow_err_o | output | 1 | Trap refused at full depth |
| illegal_ret_err_o | output | 1 | Return refused at level 0 |

## Verification
The bench uses the default build: 32-bit addresses, an 8-bit state word, 9-bit trap types and a depth of 6. With a depth that small, random traffic biased toward traps reaches the full stack again and again, so overflow attempts and level-0 returns occur often. The 9-bit type covers both table halves. Directed sequences fill the stack completely, attempt an overflow, drain the stack in LIFO order, and issue simultaneous trap and return requests.

// File: rtl/trap_nest_pkg.sv
package trap_nest_pkg;
  parameter int unsigned PC_W       = 32;
  parameter int unsigned PS_W       = 8;
  parameter int unsigned TT_W       = 9;
  parameter int unsigned DEPTH      = 6;
  parameter int unsigned INSN_BYTES = 4;
  parameter int unsigned SLOT_INSNS = 8;

  localparam int unsigned SLOT_SHIFT = $clog2(INSN_BYTES * SLOT_INSNS);
  localparam int unsigned TBL_W      = TT_W + SLOT_SHIFT;
  localparam int unsigned LVL_W      = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] npc;
    logic [PS_W-1:0] ps;
  } trap_ctx_t;
endpackage

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_nest_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PC_W-1:0] wdata_i,
  input  logic [TT_W-1:0] tt_i,
  output logic [PC_W-1:0] vec_pc_o,
  output logic [PC_W-1:0] vec_npc_o
);
  logic [PC_W-TBL_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= '0;
    else if (we_i) base_q <= wdata_i[PC_W-1:TBL_W];
  end

  // base is table aligned, so the slot offset is a plain concatenation
  assign vec_pc_o  = {base_q, tt_i, {SLOT_SHIFT{1'b0}}};
  assign vec_npc_o = vec_pc_o + PC_W'(INSN_BYTES);
endmodule

// File: rtl/trap_level_ctrl.sv
module trap_level_ctrl
  import trap_nest_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_req_i,
  input  logic             ret_req_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             ovf_o,
  output logic             ill_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             full, empty;

  assign full  = (lvl_q == LVL_W'(DEPTH));
  assign empty = (lvl_q == '0);

  // a trap request always claims the cycle; a return only runs alone
  assign push_o = trap_req_i && !full;
  assign ovf_o  = trap_req_i && full;
  assign pop_o  = !trap_req_i && ret_req_i && !empty;
  assign ill_o  = !trap_req_i && ret_req_i && empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= '0;
    else if (push_o) lvl_q <= lvl_q + 1'b1;
    else if (pop_o)  lvl_q <= lvl_q - 1'b1;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/trap_ctx_stack.sv
module trap_ctx_stack
  import trap_nest_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  trap_ctx_t        wr_ctx_i,
  output trap_ctx_t        top_ctx_o
);
  trap_ctx_t ctx_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ctx_q[g] <= '0;
      else if (push_i && lvl_i == LVL_W'(g))      ctx_q[g] <= wr_ctx_i;
    end
  end

  always_comb begin
    top_ctx_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (lvl_i == LVL_W'(i + 1)) top_ctx_o = ctx_q[i];
  end
endmodule

// File: rtl/trap_nest_unit.sv
module trap_nest_unit
  import trap_nest_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [PC_W-1:0]  base_wdata_i,
  input  logic             trap_req_i,
  input  logic [TT_W-1:0]  trap_type_i,
  input  logic             ret_req_i,
  input  logic [PC_W-1:0]  cur_pc_i,
  input  logic [PC_W-1:0]  cur_npc_i,
  input  logic [PS_W-1:0]  cur_pstate_i,
  output logic             trap_taken_o,
  output logic             ret_taken_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic [PC_W-1:0]  redirect_npc_o,
  output logic [PS_W-1:0]  restored_pstate_o,
  output logic [LVL_W-1:0] trap_level_o,
  output logic             overflow_err_o,
  output logic             illegal_ret_err_o
);
  logic             push, pop;
  logic [LVL_W-1:0] lvl;
  logic [PC_W-1:0]  vec_pc, vec_npc;
  trap_ctx_t        wr_ctx, top_ctx;

  trap_level_ctrl i_lvl (
    .clk_i, .rst_ni,
    .trap_req_i, .ret_req_i,
    .push_o(push), .pop_o(pop),
    .ovf_o(overflow_err_o), .ill_o(illegal_ret_err_o),
    .lvl_o(lvl)
  );

  trap_vec_gen i_vec (
    .clk_i, .rst_ni,
    .we_i(base_we_i), .wdata_i(base_wdata_i),
    .tt_i(trap_type_i),
    .vec_pc_o(vec_pc), .vec_npc_o(vec_npc)
  );

  assign wr_ctx = '{pc: cur_pc_i, npc: cur_npc_i, ps: cur_pstate_i};

  trap_ctx_stack i_stk (
    .clk_i, .rst_ni,
    .push_i(push), .lvl_i(lvl),
    .wr_ctx_i(wr_ctx), .top_ctx_o(top_ctx)
  );

  always_comb begin
    redirect_pc_o     = '0;
    redirect_npc_o    = '0;
    restored_pstate_o = '0;
    if (push) begin
      redirect_pc_o  = vec_pc;
      redirect_npc_o = vec_npc;
    end else if (pop) begin
      redirect_pc_o     = top_ctx.pc;
      redirect_npc_o    = top_ctx.npc;
      restored_pstate_o = top_ctx.ps;
    end
  end

  assign trap_taken_o = push;
  assign ret_taken_o  = pop;
  assign trap_level_o = lvl;
endmodule

// File: rtl/trap_nest_checker.sv
module trap_nest_checker
  import trap_nest_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trap_req_i,
  input logic             ret_req_i,
  input logic             trap_taken_o,
  input logic             ret_taken_o,
  input logic [PC_W-1:0]  redirect_pc_o,
  input logic [PC_W-1:0]  redirect_npc_o,
  input logic [LVL_W-1:0] trap_level_o,
  input logic             overflow_err_o,
  input logic             illegal_ret_err_o
);
  a_r2_level_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |=> trap_level_o == LVL_W'($past(trap_level_o) + 1'b1));

  a_r2_slot_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |-> (redirect_pc_o[SLOT_SHIFT-1:0] == '0 &&
                      redirect_npc_o == redirect_pc_o + PC_W'(INSN_BYTES)));

  a_r5_level_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_taken_o |=> trap_level_o == LVL_W'($past(trap_level_o) - 1'b1));

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_err_o |-> !trap_taken_o && !ret_taken_o);

  a_r6_level_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_err_o |=> $stable(trap_level_o));

  a_r7_illegal_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_ret_err_o |-> !ret_taken_o && trap_level_o == '0);

  a_r8_trap_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i && ret_req_i |-> !ret_taken_o && !illegal_ret_err_o);

  a_r9_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_level_o <= LVL_W'(DEPTH));
endmodule

bind trap_nest_unit trap_nest_checker i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .trap_req_i(trap_req_i), .ret_req_i(ret_req_i),
  .trap_taken_o(trap_taken_o), .ret_taken_o(ret_taken_o),
  .redirect_pc_o(redirect_pc_o), .redirect_npc_o(redirect_npc_o),
  .trap_level_o(trap_level_o),
  .overflow_err_o(overflow_err_o), .illegal_ret_err_o(illegal_ret_err_o)
);

// File: tb/test_trap_nest_unit.sv
module test_trap_nest_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_we_i = 1'b0;
  logic [31:0] base_wdata_i = '0;
  logic        trap_req_i = 1'b0;
  logic [8:0]  trap_type_i = '0;
  logic        ret_req_i = 1'b0;
  logic [31:0] cur_pc_i = '0, cur_npc_i = '0;
  logic [7:0]  cur_pstate_i = '0;
  logic        trap_taken_o, ret_taken_o, overflow_err_o, illegal_ret_err_o;
  logic [31:0] redirect_pc_o, redirect_npc_o;
  logic [7:0]  restored_pstate_o;
  logic [2:0]  trap_level_o;

  trap_nest_unit i_trap_nest_unit (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  int m_lvl = 0;
  logic [31:0] m_base = '0;
  logic [31:0] m_pc [6], m_npc [6];
  logic [7:0]  m_ps [6];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_of(logic [31:0] b, logic [8:0] tt);
    return (b & 32'hFFFF_C000) + ({23'd0, tt} << 5);
  endfunction

  task automatic step(bit req, logic [8:0] tt, bit ret, bit we, logic [31:0] wd,
                      logic [31:0] pc, logic [31:0] npc, logic [7:0] ps);
    bit acc, ovf, pop, ill;
    @(negedge clk_i);
    trap_req_i = req; trap_type_i = tt; ret_req_i = ret;
    base_we_i = we; base_wdata_i = wd;
    cur_pc_i = pc; cur_npc_i = npc; cur_pstate_i = ps;
    acc = req && m_lvl < 6;
    ovf = req && m_lvl == 6;
    pop = !req && ret && m_lvl > 0;
    ill = !req && ret && m_lvl == 0;
    #1;
    chk("R2 trap_taken", 64'(trap_taken_o), 64'(acc));
    chk("R6 overflow", 64'(overflow_err_o), 64'(ovf));
    chk("R8/R5 ret_taken", 64'(ret_taken_o), 64'(pop));
    chk("R7 illegal_ret", 64'(illegal_ret_err_o), 64'(ill));
    if (acc) begin
      chk("R2 R3 R4 vector", 64'(redirect_pc_o), 64'(vec_of(m_base, tt)));
      chk("R2 next vector", 64'(redirect_npc_o), 64'(vec_of(m_base, tt) + 4));
    end else if (pop) begin
      chk("R5 R9 pc", 64'(redirect_pc_o), 64'(m_pc[m_lvl-1]));
      chk("R5 R9 npc", 64'(redirect_npc_o), 64'(m_npc[m_lvl-1]));
      chk("R5 R9 pstate", 64'(restored_pstate_o), 64'(m_ps[m_lvl-1]));
    end else begin
      chk("R6 R7 no redirect", 64'(redirect_pc_o), 64'd0);
    end
    @(posedge clk_i);
    if (acc) begin
      m_pc[m_lvl] = pc; m_npc[m_lvl] = npc; m_ps[m_lvl] = ps; m_lvl++;
    end else if (pop) m_lvl--;
    if (we) m_base = wd;
    #1;
    chk("R2 R5 R6 R7 level", 64'(trap_level_o), 64'(m_lvl));
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd4242);
    #12 rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 level", 64'(trap_level_o), 64'd0);
    chk("R1 taken", 64'({trap_taken_o, ret_taken_o, overflow_err_o, illegal_ret_err_o}), 64'd0);
    // R1 base is zero: trap 0x003 lands at 0x60
    step(1, 9'h003, 0, 0, 0, 32'h100, 32'h104, 8'h11);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    // R7 return at level 0
    step(0, 0, 1, 0, 0, 0, 0, 0);
    // R3 base write with simultaneous trap uses old base
    step(1, 9'h005, 0, 1, 32'h1234_5678, 32'h200, 32'h204, 8'h22);
    // R4 software slot at top of table, new base now in effect
    step(1, 9'h1FF, 0, 0, 0, 32'h300, 32'h304, 8'h33);
    step(1, 9'h100, 0, 0, 0, 32'h400, 32'h404, 8'h44);
    step(1, 9'h0FF, 0, 0, 0, 32'h500, 32'h504, 8'h55);
    step(1, 9'h000, 0, 0, 0, 32'h600, 32'h604, 8'h66);
    step(1, 9'h080, 0, 0, 0, 32'h700, 32'h704, 8'h77);
    // R6 full: overflow, with a return alongside (R8)
    step(1, 9'h001, 0, 0, 0, 32'hDEAD, 32'hBEEF, 8'hEE);
    step(1, 9'h001, 1, 0, 0, 32'hDEAD, 32'hBEEF, 8'hEE);
    // R9 drain in LIFO order
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    // R8 trap and return together at mid level
    step(1, 9'h010, 0, 0, 0, 32'h800, 32'h804, 8'h88);
    step(1, 9'h111, 1, 0, 0, 32'h900, 32'h904, 8'h99);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    idle();
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a;
      a = $urandom;
      step(a[2:0] < 3'd4, 9'($urandom), a[3], a[7:4] == 4'd0, $urandom,
           $urandom, $urandom, 8'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule